// File: doc/BRIEF.md
# Direct-Mapped Host Mailbox and FIFO Interface

This block is the board-side end of a host interface in which every register is reached at its own offset, with no pointer register. The host sees a data port at offset 0 that carries byte-wide or word-wide entries, with the high data lane acting as offset 1. It also sees a status byte at offset 2 (read), a mask and control byte at offset 2 (write), a 6-bit mailbox pair at offset 3 and a logic reset at offset 7. Two FIFOs of parameterised depth carry data between the host and the board processor. One runs outbound (host to board) and one inbound (board to host).

The board processor uses a plain local port. It pushes inbound entries, pops outbound entries, writes the inbound mailbox and reads the outbound mailbox. The host interrupt is the OR of five status conditions, each enabled by its own bit in the mask register. The bus width in use is an input, `h_wide_i`. How that width is chosen is outside this block.

Top module: `mbx_host_if`

## Requirements
- R1: After reset the status byte reads 0x21, the mask is clear, `h_irq_o` and `board_rst_o` are low, and a mailbox read at offset 3 returns 0.
- R2: The status byte at offset 2 has these bits: 7 outbound mailbox full, 6 outbound FIFO full, 5 inbound FIFO empty, 4 outbound half full, 3 inbound half full, 2 inbound mailbox full, 1 inbound FIFO full, 0 outbound FIFO empty.
- R3: A host write at offset 0 with `h_wide_i`=1 pushes all 16 bits of `h_wdata_i`. With `h_wide_i`=0 it pushes the low byte with the upper byte zero. The local side pops entries in push order on `l_rdata_o`.
- R4: A host read at offset 0 returns the inbound head and pops it. With `h_wide_i`=0 only the low byte is returned and bits [15:8] read as zero.
- R5: A half-full flag is set while the FIFO holds at least DEPTH/2 entries.
- R6: A push into a full FIFO is dropped, and a pop from an empty FIFO does nothing. Stored entries and their order are unaffected.
- R7: Mailboxes keep only data bits [7:2]. Bits [1:0] always read back as zero.
- R8: Mask bit 7 selects mailbox readback at offset 3. When clear (the reset value) the read returns the inbound mailbox. When set it returns the outbound mailbox.
- R9: A host write at offset 3 loads the outbound mailbox, sets status bit 7 and raises `l_mbx_irq_o`. A board read (`l_mbx_rd_i`) clears both, but the stored value stays and can still be read back.
- R10: A board write (`l_mbx_wr_i`) loads the inbound mailbox and sets status bit 2. A host read at offset 3 with mask bit 7 clear clears status bit 2. With mask bit 7 set, the read leaves status bit 2 set.
- R11: `h_irq_o` is high when any enabled condition holds. Mask bit 6 enables inbound mailbox full, 5 inbound FIFO full, 3 inbound FIFO empty, 2 outbound FIFO full and 0 outbound FIFO empty. Reserved bits 4 and 1 have no effect.
- R12: A host write at offset 7 returns FIFOs, mailboxes and mask to the R1 state and pulses `board_rst_o` high for the next cycle. A host read at offset 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| h_addr_i | input | 3 | Host register offset |
| h_wr_i | input | 1 | Host write strobe, one cycle |
| h_rd_i | input | 1 | Host read strobe, one cycle |
| h_wide_i | input | 1 | 1 = word-wide data port, 0 = byte-wide |
| h_wdata_i | input | 16 | Host write data; bits [15:8] are the offset-1 lane |
| h_rdata_o | output | 16 | Host read data for the current offset |
| h_irq_o | output | 1 | Host interrupt |
| board_rst_o | output | 1 | One-cycle pulse after a write at offset 7 |
| l_push_i | input | 1 | Local push into the inbound FIFO |
| l_wdata_i | input | 16 | Local inbound entry |
| l_in_full_o | output | 1 | Inbound FIFO full |
| l_pop_i | input | 1 | Local pop from the outbound FIFO |
| l_rdata_o | output | 16 | Outbound FIFO head |
| l_out_empty_o | output | 1 | Outbound FIFO empty |
| l_mbx_wr_i | input | 1 | Local write of the inbound mailbox |
| l_mbx_wdata_i | input | 6 | Inbound mailbox data (bits [7:2]) |
| l_mbx_rd_i | input | 1 | Local read of the outbound mailbox |
| l_mbx_o | output | 8 | Outbound mailbox value, bits [1:0] zero |
| l_mbx_irq_o | output | 1 | Outbound mailbox full, toward the board |

## Verification
The assertions assume one-cycle host strobes that never overlap: a read and a write never occur in the same cycle. They also assume the local side never pops an empty outbound FIFO or pushes a full inbound FIFO unless the test deliberately aims at R6. The bench drives each host access as a single strobe on its own cycle. Its random phase consults the reference queues and skips local pushes and pops the model forbids. Overflow and underflow are then exercised only in directed steps, and each of those steps checks order and contents afterward.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_MBX  = 3'd3;
  localparam logic [2:0] A_RST  = 3'd7;

  localparam int ST_OMBX   = 7;
  localparam int ST_OFULL  = 6;
  localparam int ST_IEMPTY = 5;
  localparam int ST_OHALF  = 4;
  localparam int ST_IHALF  = 3;
  localparam int ST_IMBX   = 2;
  localparam int ST_IFULL  = 1;
  localparam int ST_OEMPTY = 0;

  localparam int MK_RSEL   = 7;
  localparam int MK_IMBX   = 6;
  localparam int MK_IFULL  = 5;
  localparam int MK_IEMPTY = 3;
  localparam int MK_OFULL  = 2;
  localparam int MK_OEMPTY = 0;
  localparam logic [7:0] MK_USED = 8'hED;

  localparam int MBX_W = 6;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          half_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign half_o  = (cnt_q >= CW'(DEPTH / 2));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !clr_i) |=> (full_o && wptr_q == $past(wptr_q)));

  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i && !clr_i) |=> (empty_o && rptr_q == $past(rptr_q)));

  p_half_with_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> half_o);
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox #(
  parameter int MW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          set_i,
  input  logic [MW-1:0] data_i,
  input  logic          clr_i,
  output logic          full_o,
  output logic [MW-1:0] val_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      val_o  <= '0;
    end else if (flush_i) begin
      full_o <= 1'b0;
      val_o  <= '0;
    end else if (set_i) begin
      full_o <= 1'b1;
      val_o  <= data_i;
    end else if (clr_i) begin
      full_o <= 1'b0;
    end
  end

  p_value_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i && !flush_i) |=> (!full_o && $stable(val_o)));
endmodule

// File: rtl/mbx_host_if.sv
module mbx_host_if
  import mbx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  h_addr_i,
  input  logic        h_wr_i,
  input  logic        h_rd_i,
  input  logic        h_wide_i,
  input  logic [15:0] h_wdata_i,
  output logic [15:0] h_rdata_o,
  output logic        h_irq_o,
  output logic        board_rst_o,
  input  logic        l_push_i,
  input  logic [15:0] l_wdata_i,
  output logic        l_in_full_o,
  input  logic        l_pop_i,
  output logic [15:0] l_rdata_o,
  output logic        l_out_empty_o,
  input  logic        l_mbx_wr_i,
  input  logic [7:2]  l_mbx_wdata_i,
  input  logic        l_mbx_rd_i,
  output logic [7:0]  l_mbx_o,
  output logic        l_mbx_irq_o
);
  localparam int DW = 16;

  logic wr_data, rd_data, wr_mask, wr_mbx, rd_mbx, soft_clr;
  logic [7:0] mask_q, status;
  logic [DW-1:0] out_wdata, in_head;
  logic o_full, o_empty, o_half, i_full, i_empty, i_half;
  logic om_full, im_full;
  logic [MBX_W-1:0] om_val, im_val;

  assign wr_data  = h_wr_i && (h_addr_i == A_DATA);
  assign rd_data  = h_rd_i && (h_addr_i == A_DATA);
  assign wr_mask  = h_wr_i && (h_addr_i == A_STAT);
  assign wr_mbx   = h_wr_i && (h_addr_i == A_MBX);
  assign rd_mbx   = h_rd_i && (h_addr_i == A_MBX);
  assign soft_clr = h_wr_i && (h_addr_i == A_RST);

  // byte mode: upper lane ignored, each entry carries one byte
  assign out_wdata = h_wide_i ? h_wdata_i : {8'h00, h_wdata_i[7:0]};

  mbx_fifo #(.DW(DW), .DEPTH(DEPTH)) i_out_fifo (
    .clk_i, .rst_ni, .clr_i(soft_clr),
    .push_i(wr_data), .wdata_i(out_wdata),
    .pop_i(l_pop_i), .rdata_o(l_rdata_o),
    .full_o(o_full), .empty_o(o_empty), .half_o(o_half)
  );

  mbx_fifo #(.DW(DW), .DEPTH(DEPTH)) i_in_fifo (
    .clk_i, .rst_ni, .clr_i(soft_clr),
    .push_i(l_push_i), .wdata_i(l_wdata_i),
    .pop_i(rd_data), .rdata_o(in_head),
    .full_o(i_full), .empty_o(i_empty), .half_o(i_half)
  );

  mbx_mailbox #(.MW(MBX_W)) i_out_mbx (
    .clk_i, .rst_ni, .flush_i(soft_clr),
    .set_i(wr_mbx), .data_i(h_wdata_i[7:2]),
    .clr_i(l_mbx_rd_i), .full_o(om_full), .val_o(om_val)
  );

  mbx_mailbox #(.MW(MBX_W)) i_in_mbx (
    .clk_i, .rst_ni, .flush_i(soft_clr),
    .set_i(l_mbx_wr_i), .data_i(l_mbx_wdata_i),
    .clr_i(rd_mbx && !mask_q[MK_RSEL]), .full_o(im_full), .val_o(im_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q      <= '0;
      board_rst_o <= 1'b0;
    end else begin
      board_rst_o <= soft_clr;
      if (soft_clr)     mask_q <= '0;
      else if (wr_mask) mask_q <= h_wdata_i[7:0] & MK_USED;
    end
  end

  always_comb begin
    status            = '0;
    status[ST_OMBX]   = om_full;
    status[ST_OFULL]  = o_full;
    status[ST_IEMPTY] = i_empty;
    status[ST_OHALF]  = o_half;
    status[ST_IHALF]  = i_half;
    status[ST_IMBX]   = im_full;
    status[ST_IFULL]  = i_full;
    status[ST_OEMPTY] = o_empty;
  end

  always_comb begin
    case (h_addr_i)
      A_DATA:  h_rdata_o = h_wide_i ? in_head : {8'h00, in_head[7:0]};
      A_STAT:  h_rdata_o = {8'h00, status};
      A_MBX:   h_rdata_o = {8'h00, mask_q[MK_RSEL] ? om_val : im_val, 2'b00};
      default: h_rdata_o = '0;
    endcase
  end

  assign h_irq_o = (mask_q[MK_IMBX]   && im_full) ||
                   (mask_q[MK_IFULL]  && i_full)  ||
                   (mask_q[MK_IEMPTY] && i_empty) ||
                   (mask_q[MK_OFULL]  && o_full)  ||
                   (mask_q[MK_OEMPTY] && o_empty);

  assign l_mbx_o       = {om_val, 2'b00};
  assign l_mbx_irq_o   = om_full;
  assign l_in_full_o   = i_full;
  assign l_out_empty_o = o_empty;

  p_soft_reset_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_clr |=> (status == 8'h21 && !h_irq_o && board_rst_o));

  p_out_mbx_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mbx && !soft_clr) |=> l_mbx_irq_o);

  p_in_mbx_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_mbx_wr_i && !soft_clr) |=> status[ST_IMBX]);

  p_rsel_keeps_in_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_mbx && mask_q[MK_RSEL] && !h_wr_i && !l_mbx_wr_i) |=>
      (status[ST_IMBX] == $past(status[ST_IMBX])));

  p_mbx_low_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_addr_i == A_MBX) |-> (h_rdata_o[1:0] == 2'b00));
endmodule

// File: tb/test_mbx_host_if.sv
module test_mbx_host_if;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] h_addr = '0;
  logic h_wr = 0, h_rd = 0, h_wide = 0;
  logic [15:0] h_wdata = '0;
  logic [15:0] h_rdata;
  logic h_irq, board_rst;
  logic l_push = 0, l_pop = 0, l_mbx_wr = 0, l_mbx_rd = 0;
  logic [15:0] l_wdata = '0;
  logic [15:0] l_rdata;
  logic l_in_full, l_out_empty, l_mbx_irq;
  logic [7:2] l_mbx_wdata = '0;
  logic [7:0] l_mbx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mbx_host_if #(.DEPTH(D)) i_mbx_host_if (
    .clk_i(clk), .rst_ni(rst_n),
    .h_addr_i(h_addr), .h_wr_i(h_wr), .h_rd_i(h_rd), .h_wide_i(h_wide),
    .h_wdata_i(h_wdata), .h_rdata_o(h_rdata), .h_irq_o(h_irq),
    .board_rst_o(board_rst),
    .l_push_i(l_push), .l_wdata_i(l_wdata), .l_in_full_o(l_in_full),
    .l_pop_i(l_pop), .l_rdata_o(l_rdata), .l_out_empty_o(l_out_empty),
    .l_mbx_wr_i(l_mbx_wr), .l_mbx_wdata_i(l_mbx_wdata), .l_mbx_rd_i(l_mbx_rd),
    .l_mbx_o(l_mbx), .l_mbx_irq_o(l_mbx_irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [2:0] a, input logic [15:0] d, input logic w);
    @(negedge clk); h_addr = a; h_wdata = d; h_wide = w; h_wr = 1;
    @(posedge clk); #1 h_wr = 0;
  endtask

  task automatic hr(input logic [2:0] a, input logic w, output logic [15:0] d);
    @(negedge clk); h_addr = a; h_wide = w; h_rd = 1; #1 d = h_rdata;
    @(posedge clk); #1 h_rd = 0;
  endtask

  task automatic lpop(output logic [15:0] d);
    @(negedge clk); l_pop = 1; #1 d = l_rdata;
    @(posedge clk); #1 l_pop = 0;
  endtask

  task automatic lpush(input logic [15:0] d);
    @(negedge clk); l_wdata = d; l_push = 1;
    @(posedge clk); #1 l_push = 0;
  endtask

  task automatic lmw(input logic [7:0] d);
    @(negedge clk); l_mbx_wdata = d[7:2]; l_mbx_wr = 1;
    @(posedge clk); #1 l_mbx_wr = 0;
  endtask

  task automatic lmr();
    @(negedge clk); l_mbx_rd = 1;
    @(posedge clk); #1 l_mbx_rd = 0;
  endtask

  task automatic stat(input string tag, input logic [7:0] e);
    logic [15:0] v;
    hr(3'd2, 1'b0, v);
    chk(tag, v, {8'h00, e});
  endtask

  function automatic logic [7:0] exp_status(input int oc, input int ic, input bit ob, input bit ib);
    return {ob, oc == D, ic == 0, oc >= D / 2, ic >= D / 2, ib, ic == D, oc == 0};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] oq[$];
    logic [15:0] iq[$];
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    stat("R1 status", 8'h21);
    chk("R1 irq", {15'h0, h_irq}, 16'h0);
    chk("R1 board_rst", {15'h0, board_rst}, 16'h0);
    hr(3'd3, 1'b0, v); chk("R1 mailbox", v, 16'h0);

    // R3 word and byte pushes
    hw(3'd0, 16'hA5C3, 1'b1);
    hw(3'd0, 16'h7E42, 1'b0);
    lpop(v); chk("R3 word entry", v, 16'hA5C3);
    lpop(v); chk("R3 byte entry", v, 16'h0042);

    // R4 host reads inbound
    lpush(16'h1234); lpush(16'h5678);
    hr(3'd0, 1'b1, v); chk("R4 word read", v, 16'h1234);
    hr(3'd0, 1'b0, v); chk("R4 byte read", v, 16'h0078);
    stat("R2 idle status", 8'h21);

    // R5/R6 outbound fill and overflow
    for (int i = 1; i <= 3; i++) hw(3'd0, 16'(i), 1'b1);
    stat("R5 below half", 8'h20);
    hw(3'd0, 16'd4, 1'b1);
    stat("R5 at half", 8'h30);
    for (int i = 5; i <= 8; i++) hw(3'd0, 16'(i), 1'b1);
    stat("R2 out full", 8'h70);
    hw(3'd0, 16'hDEAD, 1'b1);
    for (int i = 1; i <= 8; i++) begin
      lpop(v); chk("R6 order after overflow", v, 16'(i));
    end
    stat("R6 drained", 8'h21);
    lpop(v);
    hw(3'd0, 16'h0BAD, 1'b1);
    lpop(v); chk("R6 pop on empty ignored", v, 16'h0BAD);
    hr(3'd0, 1'b1, v);
    lpush(16'hBEEF);
    hr(3'd0, 1'b1, v); chk("R6 read on empty ignored", v, 16'hBEEF);

    // R7/R8/R9 outbound mailbox
    hw(3'd3, 16'h00FF, 1'b0);
    stat("R9 out mailbox full", 8'hA1);
    chk("R7 local value", {8'h0, l_mbx}, 16'h00FC);
    chk("R9 local irq", {15'h0, l_mbx_irq}, 16'h1);
    hw(3'd2, 16'h0080, 1'b0);
    hr(3'd3, 1'b0, v); chk("R8 outbound readback", v, 16'h00FC);
    lmr();
    stat("R9 cleared by board read", 8'h21);
    chk("R9 local irq low", {15'h0, l_mbx_irq}, 16'h0);
    hr(3'd3, 1'b0, v); chk("R9 value kept", v, 16'h00FC);

    // R10 inbound mailbox
    lmw(8'h57);
    stat("R10 in mailbox full", 8'h25);
    hr(3'd3, 1'b0, v); chk("R8 select outbound", v, 16'h00FC);
    stat("R10 kept with select set", 8'h25);
    hw(3'd2, 16'h0000, 1'b0);
    hr(3'd3, 1'b0, v); chk("R7 inbound value", v, 16'h0054);
    stat("R10 cleared by host read", 8'h21);

    // R11 interrupt masking
    hw(3'd2, 16'h0001, 1'b0);
    chk("R11 out empty irq", {15'h0, h_irq}, 16'h1);
    hw(3'd2, 16'h0008, 1'b0);
    chk("R11 in empty irq", {15'h0, h_irq}, 16'h1);
    for (int i = 0; i < 4; i++) hw(3'd0, 16'(i), 1'b1);
    for (int i = 0; i < D; i++) lpush(16'(i + 100));
    stat("R2 half/full mix", 8'h1A);
    hw(3'd2, 16'h0012, 1'b0);
    chk("R11 reserved bits", {15'h0, h_irq}, 16'h0);
    hw(3'd2, 16'h0004, 1'b0);
    chk("R11 out full not set", {15'h0, h_irq}, 16'h0);
    hw(3'd2, 16'h0020, 1'b0);
    chk("R11 in full irq", {15'h0, h_irq}, 16'h1);

    // R12 offset 7
    hr(3'd7, 1'b0, v);
    stat("R12 read has no effect", 8'h1A);
    chk("R12 irq unchanged", {15'h0, h_irq}, 16'h1);
    hw(3'd3, 16'h0040, 1'b0);
    hw(3'd7, 16'h0000, 1'b0);
    chk("R12 board_rst pulse", {15'h0, board_rst}, 16'h1);
    chk("R12 irq cleared", {15'h0, h_irq}, 16'h0);
    stat("R12 status reset", 8'h21);
    chk("R12 board_rst single", {15'h0, board_rst}, 16'h0);
    hw(3'd2, 16'h0080, 1'b0);
    hr(3'd3, 1'b0, v); chk("R12 mailbox cleared", v, 16'h0);
    hw(3'd2, 16'h0000, 1'b0);

    // random traffic, R2..R6 against queue model
    for (int n = 0; n < 600; n++) begin
      int op;
      logic w;
      logic [15:0] d;
      op = $urandom_range(0, 3);
      w = 1'($urandom_range(0, 1));
      d = 16'($urandom);
      case (op)
        0: begin
          hw(3'd0, d, w);
          if (oq.size() < D) oq.push_back(w ? d : {8'h00, d[7:0]});
        end
        1: if (oq.size() > 0) begin
          lpop(v); chk("R3 random local pop", v, oq.pop_front());
        end
        2: if (iq.size() < D) begin
          lpush(d); iq.push_back(d);
        end
        default: if (iq.size() > 0) begin
          logic [15:0] e;
          e = iq.pop_front();
          hr(3'd0, w, v);
          chk("R4 random host read", v, w ? e : {8'h00, e[7:0]});
        end
      endcase
      if (n % 8 == 0) stat("R2 random status", exp_status(oq.size(), iq.size(), 1'b0, 1'b0));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule